// File: doc/BRIEF.md
# Pointer Bounds Creation Unit

This execution unit takes one instruction that has already been decoded and whose operand is a memory operand, and turns it into a bound pair. The lower bound is the raw base register value, or zero when the operand has no base register. The upper bound is the one's complement of the effective address. The address is formed from base, scaled index and displacement, exactly as an address-generation instruction would form it. The pair is written into a small bound register file selected by the destination number. The unit never reads or writes memory and never changes flags.

Before anything is written, a set of mode-dependent rules decides whether the request faults. These rules cover the lock prefix, the destination number range, instruction-pointer-relative addressing, 16-bit addressing and non-canonical addresses in 64-bit mode. Any fault suppresses the write and reports a fault code. The register-to-register form of the instruction finishes as a no-op.

Requests enter through a valid/ready handshake. Each result is reported one cycle after acceptance and is held until the consumer takes it. A combinational read port exposes any bound register.

Top module: `bnd_make_unit`

## Requirements
- R1: After reset, every bound register holds zero in both bounds and `out_valid` is low.
- R2: On a write, the lower bound equals `in_base` when `in_base_vld` is 1. It equals zero when `in_base_vld` is 0.
- R3: In 64-bit mode (`in_mode`=3), the upper bound on a write is the bitwise NOT of the 64-bit sum of base, index shifted left by `in_scale`, and displacement. Base or index counts as zero when its valid flag is 0.
- R4: In modes 0 to 2 (real=0, virtual-8086=1, protected=2), the upper bound is the NOT of the low 32 bits of the same sum, with bits 63:32 equal to zero.
- R5: A request with `in_reg_form`=1 reports fault code 0 and `out_wrote`=0 and changes no bound register. This holds even when a fault condition is also present.
- R6: A request with `in_lock`=1 reports fault code 1 (invalid opcode).
- R7: In 64-bit mode, `in_rip_rel`=1 reports code 1. A destination number `in_dst` of 4 to 15 also reports code 1.
- R8: Outside 64-bit mode, only `in_dst[2:0]` selects the destination, and `in_dst[3]` is ignored. A value of 4 to 7 in those bits reports code 1.
- R9: Outside 64-bit mode, the address size is 16 bits when `in_asz_ovr` equals `in_cs_d`. A 16-bit address size reports code 1.
- R10: In 64-bit mode, an address whose bits 63:47 are not all equal reports code 2 (stack fault) when `in_ss_ref`=1 and code 3 (general protection) otherwise. Code 1 takes priority over codes 2 and 3.
- R11: Any nonzero fault code leaves every bound register unchanged and reports `out_wrote`=0. A request with no fault and `in_reg_form`=0 reports code 0 and `out_wrote`=1.
- R12: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on `out_valid` in the next cycle and is held while `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can accept a request |
| in_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected, 3 64-bit |
| in_cs_d | input | 1 | Code segment default size is 32-bit |
| in_asz_ovr | input | 1 | Address-size override prefix present |
| in_lock | input | 1 | Lock prefix present |
| in_rip_rel | input | 1 | Instruction-pointer-relative addressing |
| in_reg_form | input | 1 | Register-to-register form |
| in_ss_ref | input | 1 | Operand references the stack segment |
| in_base_vld | input | 1 | Operand has a base register |
| in_base | input | 64 | Base register value |
| in_index_vld | input | 1 | Operand has an index register |
| in_index | input | 64 | Index register value |
| in_scale | input | 2 | Index shift amount |
| in_disp | input | 64 | Sign-extended displacement |
| in_dst | input | 4 | Destination bound register number |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_fault | output | 2 | 0 none, 1 invalid opcode, 2 stack, 3 general protection |
| out_wrote | output | 1 | A bound register was written |
| rd_sel | input | 2 | Read port register select |
| rd_lb | output | 64 | Lower bound of selected register |
| rd_ub | output | 64 | Upper bound of selected register |

## Verification
On every cycle, the assertions check the following. A faulting result or a no-op leaves the whole bound file untouched. A held result does not change under backpressure. A lock or instruction-pointer-relative request in 64-bit mode yields the invalid-opcode code. Writes made outside 64-bit mode keep the upper half of the upper bound zero. The bench scenarios show the rest: the actual bound values for each mode and operand mix, the fault priority, the ignored destination bit, the handling of 16-bit addressing across modes, and the order of results under backpressure.

// File: rtl/bnd_make_unit.sv
module bnd_make_unit #(
  parameter int NBND   = 4,
  parameter int VA_W   = 48,
  parameter int RSEL_W = $clog2(NBND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic              in_cs_d,
  input  logic              in_asz_ovr,
  input  logic              in_lock,
  input  logic              in_rip_rel,
  input  logic              in_reg_form,
  input  logic              in_ss_ref,
  input  logic              in_base_vld,
  input  logic [63:0]       in_base,
  input  logic              in_index_vld,
  input  logic [63:0]       in_index,
  input  logic [1:0]        in_scale,
  input  logic [63:0]       in_disp,
  input  logic [3:0]        in_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_fault,
  output logic              out_wrote,
  input  logic [RSEL_W-1:0] rd_sel,
  output logic [63:0]       rd_lb,
  output logic [63:0]       rd_ub
);
  localparam logic [1:0] F_NONE = 2'd0;
  localparam logic [1:0] F_UD   = 2'd1;
  localparam logic [1:0] F_SS   = 2'd2;
  localparam logic [1:0] F_GP   = 2'd3;
  localparam logic [3:0] LIM64  = 4'(NBND);
  localparam logic [2:0] LIM32  = 3'(NBND);

  logic [NBND-1:0][63:0] rf_lb, rf_ub;
  logic [RSEL_W-1:0]     out_idx;
  logic                  out_long;

  logic        long_m, accept, addr16, dst_bad, ud, canon_ok, wr_n;
  logic [63:0] base_eff, scaled, ea, ub_n;
  logic [1:0]  fault_n;

  assign long_m   = (in_mode == 2'd3);
  assign accept   = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;

  assign base_eff = in_base_vld ? in_base : 64'd0;
  assign scaled   = in_index_vld ? (in_index << in_scale) : 64'd0;
  assign ea       = base_eff + scaled + in_disp;
  assign ub_n     = long_m ? ~ea : {32'd0, ~ea[31:0]};

  assign dst_bad  = long_m ? (in_dst >= LIM64) : (in_dst[2:0] >= LIM32);
  assign addr16   = !long_m && (in_asz_ovr == in_cs_d);
  assign ud       = in_lock || dst_bad || (long_m && in_rip_rel) || addr16;
  assign canon_ok = (&ea[63:VA_W-1]) || !(|ea[63:VA_W-1]);

  always_comb begin
    if (in_reg_form)            fault_n = F_NONE;
    else if (ud)                fault_n = F_UD;
    else if (long_m && !canon_ok) fault_n = in_ss_ref ? F_SS : F_GP;
    else                        fault_n = F_NONE;
  end
  assign wr_n = !in_reg_form && (fault_n == F_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= F_NONE;
      out_wrote <= 1'b0;
      out_idx   <= '0;
      out_long  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_fault <= fault_n;
      out_wrote <= wr_n;
      out_idx   <= in_dst[RSEL_W-1:0];
      out_long  <= long_m;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_lb <= '0;
      rf_ub <= '0;
    end else if (accept && wr_n) begin
      rf_lb[in_dst[RSEL_W-1:0]] <= base_eff;
      rf_ub[in_dst[RSEL_W-1:0]] <= ub_n;
    end
  end

  assign rd_lb = rf_lb[rd_sel];
  assign rd_ub = rf_ub[rd_sel];

  p_nowrite_keeps_file_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_wrote |-> $stable(rf_lb) && $stable(rf_ub));

  p_hold_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_fault) && $stable(out_wrote));

  p_lock_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_lock && !in_reg_form |=> out_fault == F_UD);

  p_riprel_faults_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && long_m && in_rip_rel && !in_reg_form |=> out_fault == F_UD);

  p_upper_zero_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wrote && !out_long |-> rf_ub[out_idx][63:32] == 32'd0);

  p_regform_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_reg_form |=> out_fault == F_NONE && !out_wrote);
endmodule

// File: tb/sim_bnd_make_unit.sv
module sim_bnd_make_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [1:0] in_mode = 0;
  logic in_cs_d = 0, in_asz_ovr = 0, in_lock = 0, in_rip_rel = 0, in_reg_form = 0, in_ss_ref = 0;
  logic in_base_vld = 0, in_index_vld = 0;
  logic [63:0] in_base = 0, in_index = 0, in_disp = 0;
  logic [1:0] in_scale = 0;
  logic [3:0] in_dst = 0;
  logic out_valid, out_ready = 1;
  logic [1:0] out_fault;
  logic out_wrote;
  logic [1:0] rd_sel = 0;
  logic [63:0] rd_lb, rd_ub;

  always #(CLK_PERIOD/2) clk = ~clk;

  bnd_make_unit u0 (.*);

  typedef struct {
    string       tag;
    logic [1:0]  f;
    logic        w;
    logic [1:0]  idx;
    logic [63:0] lb, ub;
  } exp_t;

  exp_t q[$];
  logic [63:0] m_lb [4];
  logic [63:0] m_ub [4];
  int n_chk = 0, n_bad = 0;
  bit bp = 0, done = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic send(string tag, logic [1:0] md, logic csd, logic ovr, logic lk, logic rip,
                      logic rf, logic ss, logic bv, logic [63:0] b, logic iv, logic [63:0] ix,
                      logic [1:0] sc, logic [63:0] d, logic [3:0] dst);
    exp_t e;
    logic [63:0] ea;
    logic [31:0] ea32;
    logic ud;
    @(negedge clk);
    in_mode = md; in_cs_d = csd; in_asz_ovr = ovr; in_lock = lk; in_rip_rel = rip;
    in_reg_form = rf; in_ss_ref = ss; in_base_vld = bv; in_base = b; in_index_vld = iv;
    in_index = ix; in_scale = sc; in_disp = d; in_dst = dst; in_valid = 1;
    while (!in_ready) @(negedge clk);
    ea   = (bv ? b : 64'd0) + (iv ? ix * (64'd1 << sc) : 64'd0) + d;
    ea32 = (bv ? b[31:0] : 32'd0) + (iv ? ix[31:0] * (32'd1 << sc) : 32'd0) + d[31:0];
    if (md == 3) ud = lk || rip || dst > 3;
    else         ud = lk || dst[2:0] > 3 || (ovr == csd);
    e.tag = tag;
    if (rf)      e.f = 0;
    else if (ud) e.f = 1;
    else if (md == 3 && ea[63:47] != {17{ea[47]}}) e.f = ss ? 2 : 3;
    else         e.f = 0;
    e.w   = !rf && e.f == 0;
    e.idx = dst[1:0];
    e.lb  = bv ? b : 64'd0;
    e.ub  = (md == 3) ? ~ea : {32'd0, ~ea32};
    q.push_back(e);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n && !done) begin
      check("R12 in_ready", {63'd0, in_ready}, {63'd0, !out_valid || out_ready});
      if (out_valid && out_ready) begin
        exp_t e;
        if (q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R12: actual unexpected result expected none");
        end else begin
          e = q.pop_front();
          check({e.tag, " fault"}, {62'd0, out_fault}, {62'd0, e.f});
          check({e.tag, " wrote R11"}, {63'd0, out_wrote}, {63'd0, e.w});
          if (e.w) begin m_lb[e.idx] = e.lb; m_ub[e.idx] = e.ub; end
          rd_sel = e.idx;
          #1;
          check({e.tag, " lower R2"}, rd_lb, m_lb[e.idx]);
          check({e.tag, " upper"}, rd_ub, m_ub[e.idx]);
        end
      end
    end
  end

  initial forever begin
    @(posedge clk); #2;
    out_ready = bp ? ($urandom_range(0, 2) == 0) : 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_lb[i] = 0; m_ub[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i); #1;
      check("R1 lower", rd_lb, 64'd0);
      check("R1 upper", rd_ub, 64'd0);
    end
    // R3 R2: 64-bit writes with varied operand mixes
    send("R3 full", 3,0,0,0,0, 0,0, 1,64'h0000_1234_5678_0000, 1,64'h10, 3, 64'h44, 0);
    send("R3 negdisp", 3,0,0,0,0, 0,0, 1,64'h0000_0000_0001_0000, 1,64'h3, 1, -64'sd8, 1);
    send("R2 nobase", 3,0,0,0,0, 0,0, 0,64'hDEAD_BEEF, 1,64'h100, 2, 64'h20, 2);
    send("R3 baseonly", 3,0,0,0,0, 0,0, 1,64'hFFFF_FFFF_FFFF_0000, 0,64'h5, 0, 64'h0, 3);
    // R4: 32-bit address forms
    send("R4 prot", 2,1,0,0,0, 0,0, 1,64'hAAAA_0000_FFFF_FF00, 1,64'h40, 2, 64'h200, 0);
    send("R4 real ovr", 0,0,1,0,0, 0,0, 1,64'h1000, 0,0, 0, 64'h10, 1);
    send("R4 v86 ovr", 1,0,1,0,0, 0,0, 0,64'h55, 1,64'h7, 3, 64'h1, 2);
    // R8: dst bit 3 ignored outside 64-bit mode, 4..7 fault
    send("R8 dst9", 2,1,0,0,0, 0,0, 1,64'h9999, 0,0, 0, 64'h0, 9);
    send("R8 dst6", 2,1,0,0,0, 0,0, 1,64'h1111, 0,0, 0, 64'h0, 6);
    // R9: 16-bit addressing
    send("R9 prot16 a", 2,0,0,0,0, 0,0, 1,64'h2222, 0,0, 0, 64'h0, 0);
    send("R9 prot16 b", 2,1,1,0,0, 0,0, 1,64'h2222, 0,0, 0, 64'h0, 0);
    send("R9 real16", 0,0,0,0,0, 0,0, 1,64'h3333, 0,0, 0, 64'h0, 1);
    send("R9 v86 16", 1,0,0,0,0, 0,0, 1,64'h3333, 0,0, 0, 64'h0, 1);
    // R6 R7
    send("R6 lock", 3,0,0,1,0, 0,0, 1,64'h4444, 0,0, 0, 64'h0, 0);
    send("R7 rip", 3,0,0,0,1, 0,0, 1,64'h4444, 0,0, 0, 64'h0, 0);
    send("R7 dst5", 3,0,0,0,0, 0,0, 1,64'h4444, 0,0, 0, 64'h0, 5);
    send("R7 dst12", 3,0,0,0,0, 0,0, 1,64'h4444, 0,0, 0, 64'h0, 12);
    // R10: non-canonical
    send("R10 ss", 3,0,0,0,0, 0,1, 1,64'h0000_7FFF_FFFF_FFF0, 0,0, 0, 64'h20, 1);
    send("R10 gp", 3,0,0,0,0, 0,0, 1,64'h0000_7FFF_FFFF_FFF0, 0,0, 0, 64'h20, 1);
    send("R10 ud first", 3,0,0,1,0, 0,1, 1,64'h0000_7FFF_FFFF_FFF0, 0,0, 0, 64'h20, 1);
    send("R10 canon hi", 3,0,0,0,0, 0,0, 1,64'hFFFF_8000_0000_0000, 0,0, 0, 64'h0, 1);
    // R5: register form quiet even with lock
    send("R5 regform", 3,0,0,1,1, 1,0, 1,64'h5555, 0,0, 0, 64'h0, 0);
    send("R5 regform32", 0,0,0,0,0, 1,0, 1,64'h5555, 0,0, 0, 64'h0, 2);
    // R12: backpressure, results stay ordered
    bp = 1;
    for (int k = 0; k < 24; k++)
      send("R12 bp", 2'(3 - (k % 2)), 1,0,0,0, 0,0, 1,64'(k*4096+7), 1,64'(k), 2'(k), 64'(k*3), 4'(k % 4));
    bp = 0;
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule